// File: doc/BRIEF.md
# Three-wire serial memory command receiver

This block is the slave-side front end of a serial memory that talks over three wires: a select line, a serial clock and a data pair (one input, one output). The serial clock, select and data input are brought into a fast reference clock through synchronisers, and the edges of the serial clock and select are found in that domain. While select is high, the data input is taken on each rising edge of the serial clock. Low bits that arrive before the first high bit are treated as padding and thrown away. The first high bit opens a frame, which goes on to carry an opcode, a word address and, for writes, a data word. All fields are sent most significant bit first.

A complete frame drives a small internal word array. A read streams the addressed word back on the data output. A write is committed when select falls and then starts a busy period of a set number of reference cycles. Whenever the block is selected and idle after a write, the data output reports ready or busy. A high data bit taken while that status reads ready opens the next frame straight away. When select is low the block is in standby and ignores all serial activity. After a deselect, select must stay low for a minimum number of reference cycles before a new frame is accepted.

Top module: `sermem_cmd_rx`

## Requirements
- R1: After reset the data output is not driven (`dout_oe_o` low), and selecting the block without sending anything keeps it undriven: no status is shown before the first write.
- R2: While select is low, serial clock and data-in activity is ignored and the output is not driven. Clocking a full frame with select low starts nothing.
- R3: Any number of low data bits taken after select rises and before the first high bit is discarded. The first high bit is the start bit.
- R4: After the start bit come 2 opcode bits, then a 10-bit address, then (for writes only) 16 data bits, each field MSB first. Opcode 10 is read, 01 is write, and 00 and 11 have no effect on memory or status. Address 0 and address 1023 are both reachable.
- R5: For a read, `dout_oe_o` rises and data-out is low after the edge that takes the last address bit. Each of the next 16 rising edges presents the next word bit, MSB first. The 17th rising edge releases the output.
- R6: A write frame with all 16 data bits is committed to memory when select falls. It starts a busy period of `WR_BUSY_CYC` reference cycles.
- R7: A frame ended by select falling before its last required bit is discarded: memory is unchanged and no busy period or status starts.
- R8: After a committed write, and until the next accepted start bit, the block drives status whenever it is selected and idle: data-out is low while busy and high once the write has finished.
- R9: While status reads ready, a high data bit is accepted as the start bit of a new frame. While it reads busy, a high data bit is ignored.
- R10: If select rises less than `DESEL_MIN` reference cycles after it fell, no frame is accepted during that whole select period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock, much faster than the serial clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Chip select, high = selected |
| sclk_i | input | 1 | Serial clock; data-in is taken on its rising edge |
| din_i | input | 1 | Serial data input |
| dout_o | output | 1 | Serial data output (read bits or ready/busy status) |
| dout_oe_o | output | 1 | Output enable for dout_o; low means high impedance |

## Verification
The bench sends read frames with zero, two and five padding bits, and writes to the two end addresses. A design that miscounts the padding or the field lengths returns words from the wrong address or shifted by one bit. It cuts a write short after eight data bits and sends a no-effect opcode with a full data field, and then looks for a busy status that a careless design would start and for memory that such a design would corrupt. It clocks a high bit during busy, clocks a full frame with select low, and reselects after a two-cycle gap. A design that accepted any of these would drive the output when it must stay silent. It also opens a read directly from the ready status without a deselect, which a design that only starts frames on a fresh select would miss.

// File: rtl/sermem_pkg.sv
package sermem_pkg;

  typedef enum logic [2:0] {
    FR_IDLE,
    FR_OPC,
    FR_ADR,
    FR_DAT,
    FR_RDO,
    FR_END
  } frame_st_e;

  localparam logic [1:0] OPC_RD = 2'b10;
  localparam logic [1:0] OPC_WR = 2'b01;

  // True when enough deselected cycles have elapsed.
  function automatic logic gap_met(input int low_cycles, input int min_cycles);
    return low_cycles >= min_cycles;
  endfunction

  // True on the final bit of a field of the given length.
  function automatic logic at_last(input int idx, input int len);
    return idx == len - 1;
  endfunction

endpackage

// File: rtl/sermem_sync.sv
module sermem_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain[s] <= '0;
        else         chain[s] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain[s] <= '0;
        else         chain[s] <= chain[s-1];
      end
    end
  end

  assign sync_o = chain[STAGES-1];

endmodule

// File: rtl/sermem_array.sv
module sermem_array #(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 16,
  parameter int WR_BUSY_CYC = 200
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              wr_go_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              busy_o
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int BW    = $clog2(WR_BUSY_CYC + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [BW-1:0]     busy_cnt;

  always_ff @(posedge clk_i) begin
    if (wr_go_i) mem[wr_addr_i] <= wr_data_i;
  end

  assign rd_data_o = mem[rd_addr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               busy_cnt <= '0;
    else if (wr_go_i)          busy_cnt <= BW'(WR_BUSY_CYC);
    else if (busy_cnt != '0)   busy_cnt <= busy_cnt - 1'b1;
  end

  assign busy_o = busy_cnt != '0;

  AST_WR_ONLY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_go_i |-> !busy_o); // R6

  AST_BUSY_AFTER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_go_i |=> busy_o); // R6

endmodule

// File: rtl/sermem_frame.sv
module sermem_frame
  import sermem_pkg::*;
#(
  parameter int OP_W      = 2,
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 16,
  parameter int DESEL_MIN = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_s_i,
  input  logic              sel_rise_i,
  input  logic              sel_fall_i,
  input  logic              bit_stb_i,
  input  logic              din_s_i,
  input  logic              busy_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              wr_go_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              start_o,
  output logic              dout_o,
  output logic              oe_o
);

  localparam int LEN_MAX = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
  localparam int CNT_W   = $clog2(LEN_MAX + 2);
  localparam int GAP_W   = $clog2(DESEL_MIN + 1);

  frame_st_e         st;
  logic [CNT_W-1:0]  idx;
  logic [OP_W-1:0]   op;
  logic [ADDR_W-1:0] adr;
  logic [DATA_W-1:0] dat;
  logic [DATA_W-1:0] rsr;
  logic              rd_bit;
  logic              rd_drv;
  logic              armed;
  logic              stat;
  logic [GAP_W-1:0]  gap;

  // Start bit: first high bit while idle, armed and not busy.
  assign start_o   = bit_stb_i && din_s_i && (st == FR_IDLE) && armed && !busy_i;
  assign rd_addr_o = {adr[ADDR_W-2:0], din_s_i};
  assign wr_go_o   = sel_fall_i && (st == FR_END) && (op == OPC_WR);
  assign wr_addr_o = adr;
  assign wr_data_o = dat;

  // Deselect gap tracking.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap   <= GAP_W'(DESEL_MIN);
      armed <= 1'b0;
    end else begin
      if (sel_s_i)                       gap <= '0;
      else if (gap != GAP_W'(DESEL_MIN)) gap <= gap + 1'b1;
      if (sel_fall_i)      armed <= 1'b0;
      else if (sel_rise_i) armed <= gap_met(int'(gap), DESEL_MIN);
    end
  end

  // Status mode: from a committed write until the next start bit.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      stat <= 1'b0;
    else if (wr_go_o) stat <= 1'b1;
    else if (start_o) stat <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st     <= FR_IDLE;
      idx    <= '0;
      op     <= '0;
      adr    <= '0;
      dat    <= '0;
      rsr    <= '0;
      rd_bit <= 1'b0;
      rd_drv <= 1'b0;
    end else if (!sel_s_i) begin
      st     <= FR_IDLE;
      rd_drv <= 1'b0;
    end else if (bit_stb_i) begin
      case (st)
        FR_IDLE: if (start_o) begin
          st  <= FR_OPC;
          idx <= '0;
        end
        FR_OPC: begin
          op <= {op[OP_W-2:0], din_s_i};
          if (at_last(int'(idx), OP_W)) begin
            st  <= FR_ADR;
            idx <= '0;
          end else idx <= idx + 1'b1;
        end
        FR_ADR: begin
          adr <= rd_addr_o;
          idx <= idx + 1'b1;
          if (at_last(int'(idx), ADDR_W)) begin
            idx <= '0;
            if (op == OPC_RD) begin
              st     <= FR_RDO;
              rsr    <= rd_data_i;
              rd_bit <= 1'b0;
              rd_drv <= 1'b1;
            end else if (op == OPC_WR) st <= FR_DAT;
            else                        st <= FR_END;
          end
        end
        FR_DAT: begin
          dat <= {dat[DATA_W-2:0], din_s_i};
          idx <= idx + 1'b1;
          if (at_last(int'(idx), DATA_W)) st <= FR_END;
        end
        FR_RDO: begin
          if (idx == CNT_W'(DATA_W)) begin
            st     <= FR_END;
            rd_drv <= 1'b0;
          end else begin
            rd_bit <= rsr[DATA_W-1];
            rsr    <= {rsr[DATA_W-2:0], 1'b0};
            idx    <= idx + 1'b1;
          end
        end
        FR_END:  ;
        default: st <= FR_IDLE;
      endcase
    end
  end

  assign oe_o   = sel_s_i && (rd_drv || (stat && st == FR_IDLE));
  assign dout_o = rd_drv ? rd_bit : !busy_i;

  AST_STANDBY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_s_i |=> (st == FR_IDLE) && !rd_drv); // R2

  AST_NO_READ_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_drv) |-> !busy_i); // R9

  AST_READ_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == FR_RDO && bit_stb_i && idx == CNT_W'(DATA_W)) |=> !oe_o); // R5

  AST_NO_START_UNARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_rise_i && !gap_met(int'(gap), DESEL_MIN)) |=> !armed); // R10

endmodule

// File: rtl/sermem_cmd_rx.sv
module sermem_cmd_rx #(
  parameter int OP_W        = 2,
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 16,
  parameter int WR_BUSY_CYC = 200,
  parameter int DESEL_MIN   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_i,
  input  logic sclk_i,
  input  logic din_i,
  output logic dout_o,
  output logic dout_oe_o
);

  logic [2:0]        pins_s;
  logic              sel_s, sclk_s, din_s;
  logic              sel_q, sclk_q;
  logic              sel_rise, sel_fall, bit_stb;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [DATA_W-1:0] rd_data, wr_data;
  logic              wr_go, busy, start;

  sermem_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({sel_i, sclk_i, din_i}),
    .sync_o  (pins_s)
  );

  assign {sel_s, sclk_s, din_s} = pins_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= 1'b0;
      sclk_q <= 1'b0;
    end else begin
      sel_q  <= sel_s;
      sclk_q <= sclk_s;
    end
  end

  assign sel_rise = sel_s && !sel_q;
  assign sel_fall = !sel_s && sel_q;
  assign bit_stb  = sclk_s && !sclk_q && sel_s;

  sermem_frame #(
    .OP_W(OP_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DESEL_MIN(DESEL_MIN)
  ) i_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_s_i    (sel_s),
    .sel_rise_i (sel_rise),
    .sel_fall_i (sel_fall),
    .bit_stb_i  (bit_stb),
    .din_s_i    (din_s),
    .busy_i     (busy),
    .rd_addr_o  (rd_addr),
    .rd_data_i  (rd_data),
    .wr_go_o    (wr_go),
    .wr_addr_o  (wr_addr),
    .wr_data_o  (wr_data),
    .start_o    (start),
    .dout_o     (dout_o),
    .oe_o       (dout_oe_o)
  );

  sermem_array #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WR_BUSY_CYC(WR_BUSY_CYC)
  ) i_array (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data),
    .wr_go_i   (wr_go),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .busy_o    (busy)
  );

  AST_START_NEEDS_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |-> sel_q); // R2

endmodule

// File: tb/test_sermem_cmd_rx.sv
`timescale 1ns/1ps
module test_sermem_cmd_rx;

  localparam int BUSY  = 200;
  localparam int DESEL = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0, sclk = 1'b0, din = 1'b0;
  logic dout, dout_oe;

  int n_chk = 0, n_bad = 0;
  logic [15:0] model [1024];
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic        rd_phase = 1'b0;
  int          mon_n = 0;
  logic [16:0] mon_sh = '0;

  always #10 clk = ~clk;

  sermem_cmd_rx #(.WR_BUSY_CYC(BUSY), .DESEL_MIN(DESEL)) i_sermem_cmd_rx (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .sclk_i(sclk), .din_i(din),
    .dout_o(dout), .dout_oe_o(dout_oe)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick(input logic b);
    din = b;
    wait_clk(4);
    sclk = 1'b1;
    wait_clk(8);
    sclk = 1'b0;
    wait_clk(4);
  endtask

  task automatic desel();
    sel = 1'b0;
    din = 1'b0;
    wait_clk(DESEL + 4);
  endtask

  task automatic pre(input int dummies, input logic [1:0] op);
    sel = 1'b1;
    wait_clk(4);
    for (int i = 0; i < dummies; i++) tick(1'b0);
    tick(1'b1);
    for (int i = 1; i >= 0; i--) tick(op[i]);
  endtask

  task automatic do_write(input int dummies, input logic [9:0] a,
                          input logic [15:0] d, input int nbits);
    pre(dummies, 2'b01);
    for (int i = 9; i >= 0; i--) tick(a[i]);
    for (int i = 0; i < nbits; i++) tick(d[15-i]);
    desel();
    if (nbits == 16) model[a] = d;
  endtask

  task automatic do_read(input int dummies, input logic [9:0] a, input string tag);
    exp_q.push_back(model[a]);
    tag_q.push_back(tag);
    pre(dummies, 2'b10);
    for (int i = 9; i >= 1; i--) tick(a[i]);
    rd_phase = 1'b1;
    tick(a[0]);
    for (int i = 0; i < 17; i++) tick(1'b0);
    rd_phase = 1'b0;
    chk(dout_oe == 1'b0, "R5", "output released after 17th edge", 32'(dout_oe), 0);
    chk(mon_n == 0 && exp_q.size() == 0, "R5", "read bit count", 32'(mon_n), 0);
    desel();
  endtask

  // Monitor: collects read bits at each serial clock fall and scores them.
  initial begin
    forever begin
      @(negedge sclk);
      if (rd_phase && dout_oe) begin
        mon_sh = {mon_sh[15:0], dout};
        mon_n++;
        if (mon_n == 17) begin
          mon_n = 0;
          if (exp_q.size() == 0) begin
            chk(1'b0, "R5", "unexpected read word", 32'(mon_sh), 0);
          end else begin
            logic [15:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(mon_sh[16] == 1'b0, t, "leading bit low", 32'(mon_sh[16]), 0);
            chk(mon_sh[15:0] == e, t, "read word", 32'(mon_sh[15:0]), 32'(e));
          end
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    // R1: reset state
    chk(dout_oe == 1'b0, "R1", "oe after reset", 32'(dout_oe), 0);
    sel = 1'b1;
    wait_clk(6);
    chk(dout_oe == 1'b0, "R1", "no status before any write", 32'(dout_oe), 0);
    desel();

    // R6/R8/R9: write, busy status, ignored start, ready, start from status
    do_write(0, 10'd5, 16'hA5C3, 16);
    sel = 1'b1;
    wait_clk(6);
    chk(dout_oe == 1'b1 && dout == 1'b0, "R8", "busy status", {dout_oe, dout}, 32'b10);
    tick(1'b1);
    chk(dout_oe == 1'b1 && dout == 1'b0, "R9", "high bit ignored while busy",
        {dout_oe, dout}, 32'b10);
    wait_clk(BUSY + 10);
    chk(dout_oe == 1'b1 && dout == 1'b1, "R6", "ready after busy period",
        {dout_oe, dout}, 32'b11);
    do_read(0, 10'd5, "R9");

    // R3: padding bits before the start bit
    do_read(5, 10'd5, "R3");

    // R4: address boundaries
    do_write(3, 10'd1023, 16'h8001, 16);
    wait_clk(BUSY + 20);
    do_write(0, 10'd0, 16'h7FFE, 16);
    wait_clk(BUSY + 20);
    do_read(0, 10'd1023, "R4");
    do_read(2, 10'd0, "R4");

    // R7: truncated write
    do_write(0, 10'd5, 16'h0000, 8);
    sel = 1'b1;
    wait_clk(6);
    chk(dout_oe == 1'b0, "R7", "no status after cut frame", 32'(dout_oe), 0);
    desel();
    do_read(0, 10'd5, "R7");

    // R2: standby ignores a full frame
    for (int i = 0; i < 14; i++) begin
      tick(1'b1);
      chk(dout_oe == 1'b0, "R2", "oe during standby", 32'(dout_oe), 0);
    end
    sel = 1'b1;
    wait_clk(6);
    chk(dout_oe == 1'b0, "R2", "nothing started in standby", 32'(dout_oe), 0);
    desel();
    do_read(0, 10'd1023, "R2");

    // R10: deselect gap too short
    sel = 1'b1;
    wait_clk(4);
    sel = 1'b0;
    wait_clk(2);
    sel = 1'b1;
    wait_clk(4);
    tick(1'b1);
    tick(1'b1);
    tick(1'b0);
    for (int i = 9; i >= 0; i--) tick(1'b0);
    chk(dout_oe == 1'b0, "R10", "frame after short gap", 32'(dout_oe), 0);
    tick(1'b0);
    tick(1'b0);
    chk(dout_oe == 1'b0, "R10", "still silent", 32'(dout_oe), 0);
    desel();
    do_read(0, 10'd0, "R10");

    // R4: no-effect opcode with a full data field
    pre(0, 2'b00);
    for (int i = 9; i >= 0; i--) tick(1'b0);
    for (int i = 9; i >= 0; i--) tick(i[0]);
    for (int i = 0; i < 16; i++) tick(1'b1);
    desel();
    sel = 1'b1;
    wait_clk(6);
    chk(dout_oe == 1'b0, "R4", "no-effect opcode starts no busy", 32'(dout_oe), 0);
    desel();
    pre(0, 2'b11);
    for (int i = 9; i >= 0; i--) tick(1'b0);
    for (int i = 0; i < 16; i++) tick(1'b1);
    desel();
    do_read(0, 10'd0, "R4");
    do_read(0, 10'd5, "R4");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule